// File: doc/BRIEF.md
# Binary and Decimal Add/Subtract Unit

This block is a purely combinational 8-bit arithmetic unit for a small processor core. It adds with carry or subtracts with borrow. A decimal input switches it from plain two's-complement arithmetic to packed-BCD arithmetic, where each of the two 4-bit digits is corrected separately. Register storage and instruction decoding stay outside the block. The caller supplies the accumulator value, the operand, the carry flag, the decimal flag and the operation select. It then takes the result and the four flags back in the same cycle.

The flags in decimal mode follow the behaviour of a classic 8-bit processor and are intentionally not "clean". When adding, zero comes from the uncorrected binary sum. Negative and overflow come from the high digit before its decimal fix. When subtracting, every flag comes from the binary difference and only the result byte is corrected. The carry input acts as "not borrow" during subtraction, and the carry output reports "no borrow happened".

The block has no clock, no handshake and no internal state. Because it is a combinational unit between registers, the valid/ready stream rules do not apply to it. All ports are plain data and control pins.

Top module: `bcd_addsub_alu`

## Requirements
- R1: Binary add (decimal_i=0, subtract_i=0): result_o is (a_i + b_i + carry_i) mod 256, and carry_o is 1 exactly when that sum exceeds 255.
- R2: Binary add: ovf_o is 1 exactly when a_i and b_i have equal bit 7 and result_o bit 7 differs from a_i bit 7.
- R3: In binary mode (both add and subtract), neg_o equals result_o bit 7 and zero_o is 1 exactly when result_o is 0.
- R4: Subtract (subtract_i=1): the binary difference is a_i − b_i − (1 − carry_i). carry_o is 1 exactly when that difference is not negative. In binary mode result_o is the difference mod 256.
- R5: Binary subtract: ovf_o is 1 exactly when a_i and b_i differ in bit 7 and the difference's bit 7 differs from a_i bit 7.
- R6: Decimal add: the low digit is a_i[3:0] + b_i[3:0] + carry_i, plus 6 when that value exceeds 9. result_o[3:0] holds its low four bits.
- R7: Decimal add: the raw high digit is a_i[7:4] + b_i[7:4], plus 1 when the corrected low digit exceeds 15. The raw high digit gets 6 added when it exceeds 9. result_o[7:4] holds its low four bits, and carry_o is 1 when the corrected high digit exceeds 15.
- R8: Decimal add: zero_o is 1 exactly when (a_i + b_i + carry_i) mod 256 is 0, regardless of the corrected result.
- R9: Decimal add: neg_o is bit 3 of the raw high digit. ovf_o is 1 when that bit differs from a_i bit 7 while a_i and b_i have equal bit 7.
- R10: Decimal subtract: the low digit a_i[3:0] − b_i[3:0] − (1 − carry_i) borrows when negative. On a borrow it is reduced by 6 and the high digit a_i[7:4] − b_i[7:4] is decremented. A borrowing high digit is then reduced by 6. result_o is {high[3:0], low[3:0]}.
- R11: Decimal subtract: neg_o, zero_o, ovf_o and carry_o are exactly the binary-subtract flags of R3, R4 and R5, computed from the uncorrected difference.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 8 | Accumulator operand |
| b_i | input | 8 | Second operand |
| carry_i | input | 1 | Carry in; for subtraction 1 means no borrow |
| decimal_i | input | 1 | 1 selects packed-BCD correction |
| subtract_i | input | 1 | 1 selects subtraction, 0 addition |
| result_o | output | 8 | Arithmetic result |
| neg_o | output | 1 | Negative flag |
| ovf_o | output | 1 | Signed overflow flag |
| zero_o | output | 1 | Zero flag |
| carry_o | output | 1 | Carry out / no-borrow flag |

## Verification
Immediate assertions hold on every input change for the following relations:
- the carry/no-borrow relation against an independent magnitude comparison;
- the sign condition of overflow;
- the zero and negative flags against the binary-mode result;
- digit legality whenever both operands are valid BCD.

The decimal flag quirks can only be shown by comparing against a reference model across every combination of mode, carry and operands. These quirks are: zero taken from the unfixed sum, negative and overflow taken from the raw high digit, and subtract flags ignoring the correction. The same comparison is the only way to show the exact corrected byte for invalid BCD operands. The bench runs that full sweep plus directed corner cases such as 99+01 and 00−01.

// File: rtl/bcd_alu_pkg.sv
package bcd_alu_pkg;
  localparam int DIGIT_W   = 4;
  localparam int DATA_W    = 2 * DIGIT_W;
  localparam int DIGIT_MAX = 9;
  localparam int DIGIT_FIX = 6;
  localparam int DIGIT_TOP = (1 << DIGIT_W) - 1;

  typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/bcd_bin_core.sv
module bcd_bin_core
  import bcd_alu_pkg::*;
(
  input  word_t a_i,
  input  word_t b_i,
  input  logic  carry_i,
  input  logic  sub_i,
  output word_t sum_o,
  output logic  carry_o,
  output logic  ovf_o
);
  localparam int MSB = DATA_W - 1;

  word_t            b_eff;
  logic [DATA_W:0]  wide;

  // Subtraction reuses the adder: a + ~b + c equals a - b - (1-c) + 2^W
  always_comb begin
    b_eff = sub_i ? ~b_i : b_i;
    wide  = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, carry_i};
  end

  assign sum_o   = wide[DATA_W-1:0];
  assign carry_o = wide[DATA_W];
  assign ovf_o   = ~(a_i[MSB] ^ b_eff[MSB]) & (a_i[MSB] ^ sum_o[MSB]);

  always_comb begin
    if (!sub_i) begin
      // R1: carry out iff the sum wrapped past the top
      assert_add_carry_R1: assert (carry_o == ((sum_o < a_i) || (carry_i && (sum_o == a_i))));
    end else begin
      // R4: no-borrow iff a covers b plus the pending borrow
      assert_sub_noborrow_R4: assert (carry_o ==
        ({1'b0, a_i} >= ({1'b0, b_i} + {{DATA_W{1'b0}}, ~carry_i})));
    end
    // R2 / R5: overflow only when the result sign moved away from a
    assert_ovf_sign_R2: assert (!ovf_o || (sum_o[MSB] != a_i[MSB]));
  end
endmodule

// File: rtl/bcd_dec_add.sv
module bcd_dec_add
  import bcd_alu_pkg::*;
(
  input  word_t a_i,
  input  word_t b_i,
  input  logic  carry_i,
  output word_t digits_o,
  output logic  carry_o,
  output logic  neg_o,
  output logic  ovf_o
);
  localparam int DW  = DIGIT_W + 2;
  localparam int MSB = DATA_W - 1;
  localparam logic [DW-1:0] LIM = DW'(DIGIT_MAX);
  localparam logic [DW-1:0] FIX = DW'(DIGIT_FIX);
  localparam logic [DW-1:0] TOP = DW'(DIGIT_TOP);

  logic [DW-1:0] lo_raw, lo_fix, hi_raw, hi_fix;

  always_comb begin
    lo_raw = {2'b00, a_i[DIGIT_W-1:0]} + {2'b00, b_i[DIGIT_W-1:0]}
           + {{(DW-1){1'b0}}, carry_i};
    lo_fix = (lo_raw > LIM) ? lo_raw + FIX : lo_raw;
    hi_raw = {2'b00, a_i[DATA_W-1:DIGIT_W]} + {2'b00, b_i[DATA_W-1:DIGIT_W]}
           + {{(DW-1){1'b0}}, (lo_fix > TOP)};
    hi_fix = (hi_raw > LIM) ? hi_raw + FIX : hi_raw;
  end

  // Flags sampled from the high digit before its correction
  assign neg_o    = hi_raw[DIGIT_W-1];
  assign ovf_o    = (hi_raw[DIGIT_W-1] ^ a_i[MSB]) & ~(a_i[MSB] ^ b_i[MSB]);
  assign carry_o  = hi_fix > TOP;
  assign digits_o = {hi_fix[DIGIT_W-1:0], lo_fix[DIGIT_W-1:0]};

  logic lo_ok, hi_ok;
  always_comb begin
    lo_ok = (a_i[DIGIT_W-1:0] <= DIGIT_W'(DIGIT_MAX)) && (b_i[DIGIT_W-1:0] <= DIGIT_W'(DIGIT_MAX));
    hi_ok = (a_i[DATA_W-1:DIGIT_W] <= DIGIT_W'(DIGIT_MAX)) && (b_i[DATA_W-1:DIGIT_W] <= DIGIT_W'(DIGIT_MAX));
    if (lo_ok) begin
      assert_add_low_digit_R6: assert (digits_o[DIGIT_W-1:0] <= DIGIT_W'(DIGIT_MAX));
    end
    if (lo_ok && hi_ok) begin
      assert_add_high_digit_R7: assert (digits_o[DATA_W-1:DIGIT_W] <= DIGIT_W'(DIGIT_MAX));
    end
  end
endmodule

// File: rtl/bcd_dec_sub.sv
module bcd_dec_sub
  import bcd_alu_pkg::*;
(
  input  word_t a_i,
  input  word_t b_i,
  input  logic  carry_i,
  output word_t digits_o
);
  localparam int DW = DIGIT_W + 1;
  localparam logic [DIGIT_W-1:0] FIX = DIGIT_W'(DIGIT_FIX);

  // One extra bit per digit: its top bit is the borrow
  logic [DW-1:0]      lo_raw, hi_raw;
  logic [DIGIT_W-1:0] lo_dig, hi_dig;

  always_comb begin
    lo_raw = {1'b0, a_i[DIGIT_W-1:0]} - {1'b0, b_i[DIGIT_W-1:0]}
           - {{DIGIT_W{1'b0}}, ~carry_i};
    hi_raw = {1'b0, a_i[DATA_W-1:DIGIT_W]} - {1'b0, b_i[DATA_W-1:DIGIT_W]}
           - {{DIGIT_W{1'b0}}, lo_raw[DIGIT_W]};
    lo_dig = lo_raw[DIGIT_W-1:0] - (lo_raw[DIGIT_W] ? FIX : '0);
    hi_dig = hi_raw[DIGIT_W-1:0] - (hi_raw[DIGIT_W] ? FIX : '0);
  end

  assign digits_o = {hi_dig, lo_dig};

  always_comb begin
    if ((a_i[DIGIT_W-1:0] <= DIGIT_W'(DIGIT_MAX)) && (b_i[DIGIT_W-1:0] <= DIGIT_W'(DIGIT_MAX))
        && (a_i[DATA_W-1:DIGIT_W] <= DIGIT_W'(DIGIT_MAX)) && (b_i[DATA_W-1:DIGIT_W] <= DIGIT_W'(DIGIT_MAX))) begin
      assert_sub_digits_R10: assert ((digits_o[DIGIT_W-1:0] <= DIGIT_W'(DIGIT_MAX))
                                  && (digits_o[DATA_W-1:DIGIT_W] <= DIGIT_W'(DIGIT_MAX)));
    end
  end
endmodule

// File: rtl/bcd_addsub_alu.sv
module bcd_addsub_alu
  import bcd_alu_pkg::*;
(
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              carry_i,
  input  logic              decimal_i,
  input  logic              subtract_i,
  output logic [DATA_W-1:0] result_o,
  output logic              neg_o,
  output logic              ovf_o,
  output logic              zero_o,
  output logic              carry_o
);
  localparam int MSB = DATA_W - 1;

  word_t bin_sum, dadd_res, dsub_res;
  logic  bin_c, bin_v, dadd_c, dadd_n, dadd_v;

  bcd_bin_core u_bin (
    .a_i     (a_i),
    .b_i     (b_i),
    .carry_i (carry_i),
    .sub_i   (subtract_i),
    .sum_o   (bin_sum),
    .carry_o (bin_c),
    .ovf_o   (bin_v)
  );

  bcd_dec_add u_dadd (
    .a_i      (a_i),
    .b_i      (b_i),
    .carry_i  (carry_i),
    .digits_o (dadd_res),
    .carry_o  (dadd_c),
    .neg_o    (dadd_n),
    .ovf_o    (dadd_v)
  );

  bcd_dec_sub u_dsub (
    .a_i      (a_i),
    .b_i      (b_i),
    .carry_i  (carry_i),
    .digits_o (dsub_res)
  );

  always_comb begin
    // Zero always follows the uncorrected binary value
    zero_o = (bin_sum == '0);
    if (decimal_i && !subtract_i) begin
      result_o = dadd_res;
      carry_o  = dadd_c;
      neg_o    = dadd_n;
      ovf_o    = dadd_v;
    end else begin
      result_o = decimal_i ? dsub_res : bin_sum;
      carry_o  = bin_c;
      neg_o    = bin_sum[MSB];
      ovf_o    = bin_v;
    end
  end

  always_comb begin
    if (!decimal_i) begin
      assert_bin_flags_R3: assert ((zero_o == (result_o == '0)) && (neg_o == result_o[MSB]));
    end
    if (decimal_i && subtract_i) begin
      assert_dec_sub_carry_R11: assert (carry_o ==
        ({1'b0, a_i} >= ({1'b0, b_i} + {{DATA_W{1'b0}}, ~carry_i})));
    end
  end
endmodule

// File: tb/bcd_addsub_alu_tb.sv
`timescale 1ns/1ps
module bcd_addsub_alu_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [7:0] a, b, res;
  logic cin, dec, sub, n, v, z, c;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  bcd_addsub_alu u_dut (
    .a_i(a), .b_i(b), .carry_i(cin), .decimal_i(dec), .subtract_i(sub),
    .result_o(res), .neg_o(n), .ovf_o(v), .zero_o(z), .carry_o(c)
  );

  // Returns {c, z, v, n, res[7:0]}
  function automatic logic [11:0] model(int aa, int bb, int ci, int dm, int sm);
    int t, al, ah, r, fc, fz, fv, fn;
    if (sm == 0) begin
      t = aa + bb + ci;
      if (dm == 0) begin
        r = t & 255; fc = (t > 255); fz = (r == 0); fn = (r >> 7) & 1;
        fv = (((aa ^ bb) & 128) == 0) && (((aa ^ t) & 128) != 0);
      end else begin
        al = (aa & 15) + (bb & 15) + ci;
        if (al > 9) al += 6;
        ah = (aa >> 4) + (bb >> 4) + ((al > 15) ? 1 : 0);
        fz = ((t & 255) == 0);
        fn = (ah >> 3) & 1;
        fv = ((((ah << 4) ^ aa) & 128) != 0) && (((aa ^ bb) & 128) == 0);
        if (ah > 9) ah += 6;
        fc = (ah > 15);
        r = ((ah & 15) << 4) | (al & 15);
      end
    end else begin
      t = aa - bb - (1 - ci);
      fc = (t >= 0); fz = ((t & 255) == 0); fn = (t >> 7) & 1;
      fv = (((aa ^ t) & 128) != 0) && (((aa ^ bb) & 128) != 0);
      r = t & 255;
      if (dm != 0) begin
        al = (aa & 15) - (bb & 15) - (1 - ci);
        ah = (aa >> 4) - (bb >> 4);
        if ((al & 16) != 0) begin al -= 6; ah -= 1; end
        if ((ah & 16) != 0) ah -= 6;
        r = ((ah & 15) << 4) | (al & 15);
      end
    end
    return {fc[0], fz[0], fv[0], fn[0], r[7:0]};
  endfunction

  task automatic cmp(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s a=%02h b=%02h cin=%0d dec=%0d sub=%0d actual=%0h expected=%0h",
               tag, what, a, b, cin, dec, sub, act, exp);
    end
  endtask

  task automatic apply(int aa, int bb, int ci, int dm, int sm);
    a = aa[7:0]; b = bb[7:0]; cin = ci[0]; dec = dm[0]; sub = sm[0];
    #1;
  endtask

  // Compare every output against the model, each field under its requirement
  task automatic check_model();
    logic [11:0] e;
    e = model(a, b, cin, dec, sub);
    if (!dec && !sub) begin
      cmp("R1", "result", res, e[7:0]); cmp("R1", "carry", c, e[11]);
      cmp("R2", "ovf", v, e[9]); cmp("R3", "neg", n, e[8]); cmp("R3", "zero", z, e[10]);
    end else if (!dec) begin
      cmp("R4", "result", res, e[7:0]); cmp("R4", "carry", c, e[11]);
      cmp("R5", "ovf", v, e[9]); cmp("R3", "neg", n, e[8]); cmp("R3", "zero", z, e[10]);
    end else if (!sub) begin
      cmp("R6", "low digit", res[3:0], e[3:0]); cmp("R7", "high digit", res[7:4], e[7:4]);
      cmp("R7", "carry", c, e[11]); cmp("R8", "zero", z, e[10]);
      cmp("R9", "neg", n, e[8]); cmp("R9", "ovf", v, e[9]);
    end else begin
      cmp("R10", "result", res, e[7:0]); cmp("R11", "carry", c, e[11]);
      cmp("R11", "zero", z, e[10]); cmp("R11", "neg", n, e[8]); cmp("R11", "ovf", v, e[9]);
    end
  endtask

  task automatic test_idle_state();
    apply(0, 0, 0, 0, 0);
    cmp("R1", "idle result", res, 0); cmp("R3", "idle zero", z, 1);
    cmp("R1", "idle carry", c, 0); cmp("R2", "idle ovf", v, 0);
  endtask

  task automatic test_binary_corners();
    apply(8'h7F, 8'h01, 0, 0, 0);   // signed overflow into negative
    cmp("R2", "7F+01 ovf", v, 1); cmp("R3", "7F+01 neg", n, 1); cmp("R1", "7F+01 res", res, 8'h80);
    apply(8'hFF, 8'h00, 1, 0, 0);   // wrap to zero with carry
    cmp("R1", "FF+00+1 carry", c, 1); cmp("R3", "FF+00+1 zero", z, 1);
    apply(8'h00, 8'h01, 1, 0, 1);   // borrow
    cmp("R4", "00-01 res", res, 8'hFF); cmp("R4", "00-01 carry", c, 0);
    apply(8'h80, 8'h01, 1, 0, 1);   // subtract overflow
    cmp("R5", "80-01 ovf", v, 1); cmp("R4", "80-01 res", res, 8'h7F);
  endtask

  task automatic test_decimal_corners();
    apply(8'h99, 8'h01, 0, 1, 0);   // 99+01: result 00 but zero from binary 9A
    cmp("R7", "99+01 res", res, 8'h00); cmp("R7", "99+01 carry", c, 1);
    cmp("R8", "99+01 zero", z, 0);
    apply(8'h50, 8'h50, 0, 1, 0);   // raw high digit 10 drives N and V
    cmp("R9", "50+50 neg", n, 1); cmp("R9", "50+50 ovf", v, 1);
    cmp("R7", "50+50 res", res, 8'h00); cmp("R7", "50+50 carry", c, 1);
    apply(8'h09, 8'h01, 0, 1, 0);   // low digit correction
    cmp("R6", "09+01 res", res, 8'h10);
    apply(8'h00, 8'h01, 1, 1, 1);   // 00-01 decimal
    cmp("R10", "00-01 res", res, 8'h99); cmp("R11", "00-01 carry", c, 0);
    cmp("R11", "00-01 neg", n, 1); cmp("R11", "00-01 zero", z, 0);
    apply(8'h10, 8'h01, 1, 1, 1);
    cmp("R10", "10-01 res", res, 8'h09); cmp("R11", "10-01 carry", c, 1);
  endtask

  task automatic sweep(int dm, int sm);
    for (int ci = 0; ci < 2; ci++)
      for (int aa = 0; aa < 256; aa++)
        for (int bb = 0; bb < 256; bb++) begin
          apply(aa, bb, ci, dm, sm);
          check_model();
        end
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    a = '0; b = '0; cin = 0; dec = 0; sub = 0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_idle_state();
    test_binary_corners();
    test_decimal_corners();
    sweep(0, 0);
    sweep(0, 1);
    sweep(1, 0);
    sweep(1, 1);
    finish_run();
  end
endmodule